// File: doc/BRIEF.md
# Precise Exception Status Pipeline

This block keeps exception bookkeeping precise in a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each instruction carries a status vector through the four pipeline registers that follow fetch. Whenever a stage detects a fault for the instruction it currently holds, the matching bit is posted into that instruction's vector. Nothing is acted on at the moment a fault is raised. The vector only suppresses the instruction's own state-changing writes while it travels. It is resolved when the instruction reaches writeback, so faults are always taken in program order.

When an instruction in writeback has a non-empty vector, the block takes the exception in that cycle. It pulses a flush that empties every in-flight slot, drops the instruction being fetched in that cycle, and asks for a trap fetch in the following cycle. It also latches the faulting PC together with a cause code for the highest-priority posted cause. The saved cause stays valid until the handler acknowledges it.

Instructions enter through a valid-qualified fetch port with no ready signal. The tracker moves every cycle and never applies back-pressure, so each valid beat is accepted on the clock edge where it is presented. All other pins are plain control and status.

Top module: `precise_exc_tracker`

## Requirements
- R1: While reset is asserted, flush, trap fetch, cause valid, both write enables, the cause code and the saved PC are all zero.
- R2: A cause input is posted only to a valid instruction in its stage. A cause raised while that stage is empty is dropped and never causes a flush.
- R3: The cause code is 1 plus the index of the lowest set bit of the vector. Vector bits are 0 IF page fault, 1 IF misaligned, 2 IF protection, 3 ID illegal opcode, 4 EX arithmetic, 5 MEM page fault, 6 MEM misaligned, 7 MEM protection. Within `if_cause_i` and `mem_cause_i`, bit 0 is page fault, bit 1 is misaligned and bit 2 is protection.
- R4: `mem_wr_en_o` equals `mem_wr_req_i` AND a valid instruction in MEM AND no cause posted to it (counting this cycle's MEM cause) AND no flush in this cycle.
- R5: `wb_wr_en_o` equals `wb_wr_req_i` AND a valid instruction in WB with an empty vector.
- R6: `flush_o` is high in exactly the cycle where a valid instruction with a non-empty vector sits in WB.
- R7: `trap_fetch_o` is high in the cycle after a flush and in no other cycle.
- R8: A flush loads the WB instruction's PC into `epc_o`, loads its code into `cause_code_o` and sets `cause_valid_o` from the next cycle. These hold until `cause_ack_i` clears the flag and the code. A flush in the same cycle as an acknowledge wins and overwrites any held cause.
- R9: A flush empties all in-flight slots and discards the instruction presented at fetch in that cycle, so none of them later writes or faults.
- R10: An older instruction's exception is taken even when a younger one raised its fault earlier in time. The younger fault is discarded by the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid_i | input | 1 | Instruction presented at fetch this cycle |
| fetch_pc_i | input | PC_W | PC of the fetched instruction |
| if_cause_i | input | 3 | Fetch faults of the fetched instruction |
| id_illegal_i | input | 1 | Illegal opcode for the instruction in decode |
| ex_arith_i | input | 1 | Arithmetic fault for the instruction in execute |
| mem_cause_i | input | 3 | Data-access faults for the instruction in memory |
| mem_wr_req_i | input | 1 | Memory stage wants to write data memory |
| wb_wr_req_i | input | 1 | Writeback stage wants to write the register file |
| cause_ack_i | input | 1 | Handler acknowledge, clears the saved cause |
| mem_wr_en_o | output | 1 | Gated data-memory write enable |
| wb_wr_en_o | output | 1 | Gated register-file write enable |
| flush_o | output | 1 | Exception taken, empty all in-flight slots |
| trap_fetch_o | output | 1 | Fetch the trap entry in this cycle |
| cause_valid_o | output | 1 | Saved cause is pending |
| cause_code_o | output | 4 | Saved cause code |
| epc_o | output | PC_W | Saved faulting PC |

## Verification
Single isolated instructions are sent with every mix of cause bits, including bits from several stages at once. This separates the priority order from any order in time and shows which write enable each mix suppresses. Back-to-back groups of instructions then place faults on an older and a younger instruction in the same cycle, or the younger one first. These runs show that the oldest fault wins, and that the flush kills both the younger instructions and the beat fetched in the flush cycle. Causes driven into empty stages, and an acknowledge that collides with a new exception, cover the remaining edge cases.

// File: rtl/pexc_pkg.sv
package pexc_pkg;
  // Vector layout: stage groups in program-stage order, lowest index wins.
  localparam int N_IF    = 3;
  localparam int N_MEM   = 3;
  localparam int POS_IF  = 0;
  localparam int POS_ID  = POS_IF + N_IF;
  localparam int POS_EX  = POS_ID + 1;
  localparam int POS_MEM = POS_EX + 1;
  localparam int VEC_W   = POS_MEM + N_MEM;
  localparam int CODE_W  = $clog2(VEC_W + 1);
  localparam int NSLOT   = 4;  // ID, EX, MEM, WB registers

  typedef enum logic [CODE_W-1:0] {
    CODE_NONE     = 4'd0,
    CODE_IF_PAGE  = 4'd1,
    CODE_IF_ALIGN = 4'd2,
    CODE_IF_PROT  = 4'd3,
    CODE_ID_ILL   = 4'd4,
    CODE_EX_ARITH = 4'd5,
    CODE_MEM_PAGE = 4'd6,
    CODE_MEM_ALGN = 4'd7,
    CODE_MEM_PROT = 4'd8
  } exc_code_e;
endpackage

// File: rtl/exc_stage_slot.sv
module exc_stage_slot #(
  parameter int PC_W  = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             in_valid_i,
  input  logic [PC_W-1:0]  in_pc_i,
  input  logic [VEC_W-1:0] in_vec_i,
  input  logic [VEC_W-1:0] post_i,
  output logic             out_valid_o,
  output logic [PC_W-1:0]  out_pc_o,
  output logic [VEC_W-1:0] out_vec_o
);
  // Causes posted by the stage are merged as the instruction leaves it.
  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      out_valid_o <= 1'b0;
      out_pc_o    <= '0;
      out_vec_o   <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      out_pc_o    <= in_valid_i ? in_pc_i : '0;
      out_vec_o   <= in_valid_i ? (in_vec_i | post_i) : '0;
    end
  end
endmodule

// File: rtl/exc_prio_enc.sv
module exc_prio_enc #(
  parameter int VEC_W  = 8,
  parameter int CODE_W = 4
) (
  input  logic [VEC_W-1:0]  vec_i,
  output logic [CODE_W-1:0] code_o
);
  // Lowest set bit wins; code is its index plus one, zero when empty.
  always_comb begin
    code_o = '0;
    for (int i = VEC_W - 1; i >= 0; i--) begin
      if (vec_i[i]) code_o = CODE_W'(i + 1);
    end
  end
endmodule

// File: rtl/exc_trap_ctrl.sv
module exc_trap_ctrl
  import pexc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_valid_i,
  input  logic [PC_W-1:0]   wb_pc_i,
  input  logic [VEC_W-1:0]  wb_vec_i,
  input  logic              ack_i,
  output logic              take_o,
  output logic              trap_fetch_o,
  output logic              cause_valid_o,
  output logic [CODE_W-1:0] cause_code_o,
  output logic [PC_W-1:0]   epc_o
);
  logic [CODE_W-1:0] win_code;
  exc_code_e         saved_q;

  assign take_o = wb_valid_i && (|wb_vec_i);

  exc_prio_enc #(.VEC_W(VEC_W), .CODE_W(CODE_W)) enc_i (
    .vec_i  (wb_vec_i),
    .code_o (win_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_fetch_o  <= 1'b0;
      cause_valid_o <= 1'b0;
      saved_q       <= CODE_NONE;
      epc_o         <= '0;
    end else begin
      trap_fetch_o <= take_o;
      if (take_o) begin
        cause_valid_o <= 1'b1;
        saved_q       <= exc_code_e'(win_code);
        epc_o         <= wb_pc_i;
      end else if (ack_i) begin
        cause_valid_o <= 1'b0;
        saved_q       <= CODE_NONE;
      end
    end
  end

  assign cause_code_o = saved_q;
endmodule

// File: rtl/precise_exc_tracker.sv
module precise_exc_tracker
  import pexc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid_i,
  input  logic [PC_W-1:0]   fetch_pc_i,
  input  logic [N_IF-1:0]   if_cause_i,
  input  logic              id_illegal_i,
  input  logic              ex_arith_i,
  input  logic [N_MEM-1:0]  mem_cause_i,
  input  logic              mem_wr_req_i,
  input  logic              wb_wr_req_i,
  input  logic              cause_ack_i,
  output logic              mem_wr_en_o,
  output logic              wb_wr_en_o,
  output logic              flush_o,
  output logic              trap_fetch_o,
  output logic              cause_valid_o,
  output logic [CODE_W-1:0] cause_code_o,
  output logic [PC_W-1:0]   epc_o
);
  localparam int S_MEM = NSLOT - 2;
  localparam int S_WB  = NSLOT - 1;

  logic [NSLOT-1:0] in_valid;
  logic [PC_W-1:0]  in_pc   [NSLOT];
  logic [VEC_W-1:0] in_vec  [NSLOT];
  logic [VEC_W-1:0] post    [NSLOT];
  logic [NSLOT-1:0] slot_valid;
  logic [PC_W-1:0]  slot_pc [NSLOT];
  logic [VEC_W-1:0] slot_vec[NSLOT];

  logic             take;
  logic             wb_valid;
  logic [PC_W-1:0]  wb_pc;
  logic [VEC_W-1:0] mem_vec_now;

  // Chain: fetch feeds slot 0, each slot feeds the next.
  always_comb begin
    in_valid[0] = fetch_valid_i;
    in_pc[0]    = fetch_pc_i;
    in_vec[0]   = '0;
    for (int k = 1; k < NSLOT; k++) begin
      in_valid[k] = slot_valid[k-1];
      in_pc[k]    = slot_pc[k-1];
      in_vec[k]   = slot_vec[k-1];
    end
    post[0] = VEC_W'(if_cause_i) << POS_IF;
    post[1] = VEC_W'(id_illegal_i) << POS_ID;
    post[2] = VEC_W'(ex_arith_i) << POS_EX;
    post[3] = VEC_W'(mem_cause_i) << POS_MEM;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    exc_stage_slot #(.PC_W(PC_W), .VEC_W(VEC_W)) slot_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush_i     (take),
      .in_valid_i  (in_valid[g]),
      .in_pc_i     (in_pc[g]),
      .in_vec_i    (in_vec[g]),
      .post_i      (post[g]),
      .out_valid_o (slot_valid[g]),
      .out_pc_o    (slot_pc[g]),
      .out_vec_o   (slot_vec[g])
    );
  end

  assign wb_valid    = slot_valid[S_WB];
  assign wb_pc       = slot_pc[S_WB];
  assign mem_vec_now = slot_vec[S_MEM] | post[S_WB];

  exc_trap_ctrl #(.PC_W(PC_W)) trap_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wb_valid_i    (wb_valid),
    .wb_pc_i       (wb_pc),
    .wb_vec_i      (slot_vec[S_WB]),
    .ack_i         (cause_ack_i),
    .take_o        (take),
    .trap_fetch_o  (trap_fetch_o),
    .cause_valid_o (cause_valid_o),
    .cause_code_o  (cause_code_o),
    .epc_o         (epc_o)
  );

  assign flush_o     = take;
  assign mem_wr_en_o = mem_wr_req_i && slot_valid[S_MEM] && !(|mem_vec_now) && !take;
  assign wb_wr_en_o  = wb_wr_req_i && wb_valid && !(|slot_vec[S_WB]);
endmodule

// File: rtl/precise_exc_tracker_chk.sv
module precise_exc_tracker_chk #(
  parameter int PC_W   = 32,
  parameter int NSLOT  = 4,
  parameter int CODE_W = 4,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              trap_fetch,
  input logic              cause_valid,
  input logic [CODE_W-1:0] cause_code,
  input logic [PC_W-1:0]   epc,
  input logic              ack,
  input logic              mem_wr_en,
  input logic              wb_wr_en,
  input logic              wb_valid,
  input logic [PC_W-1:0]   wb_pc,
  input logic [NSLOT-1:0]  slot_valid
);
  // R7
  trap_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> trap_fetch);
  // R7
  trap_only_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> !trap_fetch);
  // R8
  epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cause_valid && epc == $past(wb_pc)));
  // R8
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_valid && !ack && !flush) |=> (cause_valid && $stable(cause_code) && $stable(epc)));
  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !flush) |=> (!cause_valid && cause_code == '0));
  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (slot_valid == '0));
  // R4
  no_mem_write_on_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !mem_wr_en);
  // R5
  no_wb_write_on_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !wb_wr_en);
  // R6
  flush_needs_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> wb_valid);
  // R3
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_valid |-> (cause_code != '0 && cause_code <= CODE_W'(VEC_W)));
endmodule

bind precise_exc_tracker precise_exc_tracker_chk #(
  .PC_W(PC_W), .NSLOT(pexc_pkg::NSLOT), .CODE_W(pexc_pkg::CODE_W), .VEC_W(pexc_pkg::VEC_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush_o),
  .trap_fetch  (trap_fetch_o),
  .cause_valid (cause_valid_o),
  .cause_code  (cause_code_o),
  .epc         (epc_o),
  .ack         (cause_ack_i),
  .mem_wr_en   (mem_wr_en_o),
  .wb_wr_en    (wb_wr_en_o),
  .wb_valid    (wb_valid),
  .wb_pc       (wb_pc),
  .slot_valid  (slot_valid)
);

// File: tb/precise_exc_tracker_tb_top.sv
module precise_exc_tracker_tb_top;
  localparam int PC_W = 32;
  localparam int NV   = 9;
  // {if_cause[2:0], id_ill, ex_arith, mem_cause[2:0], expected code[3:0]}
  localparam logic [11:0] VECS [NV] = '{
    12'b000_0_0_000_0000,
    12'b001_0_0_000_0001,
    12'b110_0_0_000_0010,
    12'b100_0_0_001_0011,
    12'b000_1_1_000_0100,
    12'b000_0_1_010_0101,
    12'b000_0_0_100_1000,
    12'b000_0_0_111_0110,
    12'b000_0_0_110_0111
  };

  logic clk = 1'b0;
  logic rst_n;
  logic fetch_valid;
  logic [PC_W-1:0] fetch_pc;
  logic [2:0] if_cause, mem_cause;
  logic id_illegal, ex_arith, mem_wr_req, wb_wr_req, ack;
  logic mem_wr_en, wb_wr_en, flush, trap_fetch, cause_valid;
  logic [3:0] cause_code;
  logic [PC_W-1:0] epc;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  precise_exc_tracker #(.PC_W(PC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid_i(fetch_valid), .fetch_pc_i(fetch_pc),
    .if_cause_i(if_cause), .id_illegal_i(id_illegal), .ex_arith_i(ex_arith),
    .mem_cause_i(mem_cause), .mem_wr_req_i(mem_wr_req), .wb_wr_req_i(wb_wr_req),
    .cause_ack_i(ack), .mem_wr_en_o(mem_wr_en), .wb_wr_en_o(wb_wr_en),
    .flush_o(flush), .trap_fetch_o(trap_fetch), .cause_valid_o(cause_valid),
    .cause_code_o(cause_code), .epc_o(epc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic idle_inputs();
    fetch_valid = 0; fetch_pc = '0; if_cause = '0; id_illegal = 0; ex_arith = 0;
    mem_cause = '0; mem_wr_req = 0; wb_wr_req = 0; ack = 0;
  endtask

  task automatic ack_pulse();
    ack = 1; @(negedge clk); ack = 0; #1;
    check("R8 ack clears valid", 32'(cause_valid), 0);
  endtask

  // One instruction alone in the pipe; causes applied in each stage's cycle.
  task automatic run_single(input logic [31:0] pc, input logic [2:0] ifc, input logic idc,
                            input logic exc, input logic [2:0] memc, input logic [3:0] exp,
                            input bit ack_in_wb, input bit do_ack);
    fetch_valid = 1; fetch_pc = pc; if_cause = ifc; @(negedge clk);
    fetch_valid = 0; if_cause = '0; id_illegal = idc; @(negedge clk);
    id_illegal = 0; ex_arith = exc; @(negedge clk);
    ex_arith = 0; mem_cause = memc; mem_wr_req = 1; #1;
    check("R4 mem write gate", 32'(mem_wr_en), 32'(exp == 0));
    @(negedge clk);
    mem_cause = '0; mem_wr_req = 0; wb_wr_req = 1; ack = ack_in_wb; #1;
    check("R6 flush at WB", 32'(flush), 32'(exp != 0));
    check("R5 wb write gate", 32'(wb_wr_en), 32'(exp == 0));
    @(negedge clk);
    wb_wr_req = 0; ack = 0; #1;
    check("R7 trap fetch", 32'(trap_fetch), 32'(exp != 0));
    if (exp != 0) begin
      check("R3 cause code", 32'(cause_code), 32'(exp));
      check("R8 saved pc", epc, pc);
      check("R8 cause valid", 32'(cause_valid), 1);
      if (do_ack) ack_pulse();
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 flush", 32'(flush), 0);
    check("R1 trap", 32'(trap_fetch), 0);
    check("R1 cause valid", 32'(cause_valid), 0);
    check("R1 code", 32'(cause_code), 0);
    check("R1 epc", epc, 0);
    check("R1 writes", 32'({mem_wr_en, wb_wr_en}), 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // Table walk: R3 priority and R4/R5 gating across cause mixes.
    for (int i = 0; i < NV; i++) begin
      run_single(32'h1000 + 32'(i * 4), VECS[i][11:9], VECS[i][8], VECS[i][7],
                 VECS[i][6:4], VECS[i][3:0], 1'b0, 1'b1);
    end

    // R2: causes on empty stages are dropped.
    id_illegal = 1; ex_arith = 1; mem_cause = 3'b111; @(negedge clk);
    id_illegal = 0; ex_arith = 0; mem_cause = '0;
    for (int k = 0; k < 4; k++) begin
      #1; check("R2 empty-slot cause", 32'(flush), 0);
      @(negedge clk);
    end
    check("R2 no cause saved", 32'(cause_valid), 0);

    // R10/R9: load faults in MEM while next add faults in EX.
    fetch_valid = 1; fetch_pc = 32'h100; @(negedge clk);
    fetch_pc = 32'h104; @(negedge clk);
    fetch_pc = 32'h108; @(negedge clk);
    fetch_valid = 0; mem_cause = 3'b001; ex_arith = 1; @(negedge clk);
    mem_cause = '0; ex_arith = 0; mem_wr_req = 1; wb_wr_req = 1;
    fetch_valid = 1; fetch_pc = 32'h10C; #1;
    check("R6 flush older fault", 32'(flush), 1);
    check("R4 no mem write in flush", 32'(mem_wr_en), 0);
    @(negedge clk);
    fetch_valid = 0; #1;
    check("R10 older code", 32'(cause_code), 6);
    check("R10 older pc", epc, 32'h100);
    check("R9 younger fault dropped", 32'(flush), 0);
    check("R9 flushed MEM no write", 32'(mem_wr_en), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check("R9 no flush after", 32'(flush), 0);
      check("R9 no wb write after", 32'(wb_wr_en), 0);
    end
    mem_wr_req = 0; wb_wr_req = 0;
    ack_pulse();

    // R10: younger faults first in time, older wins.
    fetch_valid = 1; fetch_pc = 32'h200; @(negedge clk);
    fetch_pc = 32'h204; @(negedge clk);
    fetch_valid = 0; id_illegal = 1; @(negedge clk);
    id_illegal = 0; mem_cause = 3'b010; @(negedge clk);
    mem_cause = '0; #1;
    check("R10 flush for older", 32'(flush), 1);
    @(negedge clk); #1;
    check("R10 code of older", 32'(cause_code), 7);
    check("R10 pc of older", epc, 32'h200);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check("R10 younger discarded", 32'(flush), 0);
    end

    // R8: held cause overwritten; take beats a colliding acknowledge.
    check("R8 still held", 32'(cause_code), 7);
    run_single(32'h300, 3'b000, 1'b1, 1'b0, 3'b000, 4'd4, 1'b1, 1'b1);

    done = 1'b1;
    summary();
  end
endmodule